// File: doc/BRIEF.md
# Conservative Tile Depth Plane Evaluator

This block turns one triangle's depth plane, z = a·x + b·y + c, into a single conservative depth value for each 8x4-pixel tile of a 32x8-pixel supertile. A depth test and a tile update stage downstream consume the stream. A one-cycle start pulse loads the plane coefficients, the supertile's pixel origin, the bound mode (upper or lower depth bound) and the triangle's vertex depth range. The block then emits eight tiles on consecutive cycles, four across and two down, and flags the last one.

For each tile the block evaluates the plane at one tile corner. The signs of the two gradients select that corner. In upper-bound mode it takes the corner where the plane is largest. In lower-bound mode it takes the opposite corner. The plane is multiplied out once, at load time, for the first tile corner. After that, a column move adds 8·a and a row move adds 4·b to a running value. Every result is clamped into the triangle's vertex depth range before it leaves the block.

Top module: `tile_depth_eval`

## Requirements
- R1: After a synchronous reset, tile_valid and done are 0 and stay 0 until a start pulse is accepted.
- R2: A start sampled while the block is idle produces exactly eight output tiles on the eight following clock edges, with tile_valid high on each. tile_idx counts 0 to 7 in row-major order: tile_idx = row·4 + col, col in 0..3, row in 0..1.
- R3: When mode_max is 1 (upper bound), the tile at (col,row) reports the plane value at x = orig_x + 8·col + (8 if coef_a > 0, else 0) and y = orig_y + 4·row + (4 if coef_b > 0, else 0), clamped as in R5.
- R4: When mode_max is 0 (lower bound), the corner offset is 8 in x only when coef_a < 0, and 4 in y only when coef_b < 0, clamped as in R5.
- R5: Every tile_depth lies within [z_lo, z_hi] as captured at start. A plane value below z_lo is reported as z_lo, and one above z_hi is reported as z_hi.
- R6: done is high for exactly one cycle, together with the tile whose tile_idx is 7. The cycle after that tile, tile_valid and done are both 0.
- R7: A start pulse that arrives while tiles are still being produced is ignored. The running sequence finishes with the values loaded by the first start, and no second sequence follows.
- R8: With both gradients zero, all eight tiles report coef_c, clamped as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load pulse for a new supertile evaluation |
| mode_max | input | 1 | 1 = upper depth bound, 0 = lower depth bound |
| coef_a | input | CW | Signed x gradient of the depth plane |
| coef_b | input | CW | Signed y gradient of the depth plane |
| coef_c | input | DW | Signed plane constant |
| orig_x | input | XW | Supertile origin x in pixels |
| orig_y | input | XW | Supertile origin y in pixels |
| z_lo | input | DW | Signed smallest vertex depth |
| z_hi | input | DW | Signed largest vertex depth |
| tile_valid | output | 1 | A tile result is present this cycle |
| tile_idx | output | IW | Row-major tile number inside the supertile |
| tile_depth | output | DW | Signed conservative tile depth |
| done | output | 1 | Marks the final tile of the supertile |

## Verification
A wrong corner choice or a wrong step value in the running accumulator shows up at tile_depth on the first tile whose expected value it changes. A bad initial value is visible on tile 0, one cycle after start. A bad x step appears by tile 1. A bad row step appears at tile 4. The plane values are chosen so that each gradient sign case moves the reported depth. A walker state error shows up at once as a skipped or repeated tile_idx, or as done on the wrong cycle. A range capture fault appears only on the vectors whose plane leaves the vertex depth range, so those cases are included.

// File: rtl/tde_pkg.sv
package tde_pkg;
  typedef enum logic {BOUND_MIN = 1'b0, BOUND_MAX = 1'b1} bound_e;

  // True when the far tile edge (offset by the tile size) gives the wanted bound.
  function automatic logic take_far_edge(input bound_e m, input logic neg, input logic zero);
    if (m == BOUND_MAX) return !neg && !zero;
    return neg;
  endfunction
endpackage

// File: rtl/tde_setup.sv
module tde_setup
  import tde_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 24,
  parameter int XW = 12,
  parameter int AW = 31,
  parameter int TW = 8,
  parameter int TH = 4
) (
  input  bound_e                mode,
  input  logic signed [CW-1:0]  a,
  input  logic signed [CW-1:0]  b,
  input  logic signed [DW-1:0]  c,
  input  logic        [XW-1:0]  x0,
  input  logic        [XW-1:0]  y0,
  output logic signed [AW-1:0]  init,
  output logic signed [AW-1:0]  step_x,
  output logic signed [AW-1:0]  step_y
);
  logic                far_x, far_y;
  logic        [XW:0]  xc, yc;
  logic signed [AW-1:0] a_w, b_w, c_w, xc_w, yc_w;

  always_comb begin
    far_x = take_far_edge(mode, a[CW-1], a == '0);
    far_y = take_far_edge(mode, b[CW-1], b == '0);
    xc    = {1'b0, x0} + (far_x ? (XW+1)'(TW) : '0);
    yc    = {1'b0, y0} + (far_y ? (XW+1)'(TH) : '0);
    a_w   = {{(AW-CW){a[CW-1]}}, a};
    b_w   = {{(AW-CW){b[CW-1]}}, b};
    c_w   = {{(AW-DW){c[DW-1]}}, c};
    xc_w  = {{(AW-XW-1){1'b0}}, xc};
    yc_w  = {{(AW-XW-1){1'b0}}, yc};
    init   = a_w * xc_w + b_w * yc_w + c_w;
    step_x = a_w * $signed(AW'(TW));
    step_y = b_w * $signed(AW'(TH));
  end
endmodule

// File: rtl/tde_walker.sv
module tde_walker #(
  parameter int COLS = 4,
  parameter int ROWS = 2,
  localparam int NT  = COLS * ROWS,
  localparam int IW  = (NT > 1) ? $clog2(NT) : 1,
  localparam int CLW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RLW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          accept,
  output logic          fire,
  output logic          row_end,
  output logic          last,
  output logic [IW-1:0] idx
);
  logic           busy;
  logic [CLW-1:0] col;
  logic [RLW-1:0] row;

  always_comb begin
    accept  = go && !busy;
    fire    = busy;
    row_end = (col == CLW'(COLS - 1));
    last    = row_end && (row == RLW'(ROWS - 1));
    idx     = IW'(int'(row) * COLS + int'(col));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      col  <= '0;
      row  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      col  <= '0;
      row  <= '0;
    end else if (busy) begin
      if (row_end) begin
        col <= '0;
        if (last) busy <= 1'b0;
        else      row  <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tde_clamp.sv
module tde_clamp #(
  parameter int DW = 24,
  parameter int AW = 31,
  parameter int IW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic                 last,
  input  logic        [IW-1:0] idx,
  input  logic signed [AW-1:0] val,
  input  logic signed [DW-1:0] lo,
  input  logic signed [DW-1:0] hi,
  output logic                 o_valid,
  output logic        [IW-1:0] o_idx,
  output logic signed [DW-1:0] o_depth,
  output logic                 o_done
);
  logic signed [AW-1:0] lo_w, hi_w;
  logic signed [DW-1:0] clamped;

  always_comb begin
    lo_w = {{(AW-DW){lo[DW-1]}}, lo};
    hi_w = {{(AW-DW){hi[DW-1]}}, hi};
    if (val < lo_w)      clamped = lo;
    else if (val > hi_w) clamped = hi;
    else                 clamped = val[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_done  <= 1'b0;
      o_idx   <= '0;
      o_depth <= '0;
    end else begin
      o_valid <= fire;
      o_done  <= fire && last;
      if (fire) begin
        o_idx   <= idx;
        o_depth <= clamped;
      end
    end
  end
endmodule

// File: rtl/tile_depth_eval.sv
module tile_depth_eval
  import tde_pkg::*;
#(
  parameter int CW      = 16,
  parameter int DW      = 24,
  parameter int XW      = 12,
  parameter int TW      = 8,
  parameter int TH      = 4,
  parameter int ST_COLS = 4,
  parameter int ST_ROWS = 2,
  localparam int NT     = ST_COLS * ST_ROWS,
  localparam int IW     = (NT > 1) ? $clog2(NT) : 1,
  localparam int AW_RAW = CW + XW + 3,
  localparam int AW     = (AW_RAW > DW + 1) ? AW_RAW : DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 mode_max,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [DW-1:0] coef_c,
  input  logic        [XW-1:0] orig_x,
  input  logic        [XW-1:0] orig_y,
  input  logic signed [DW-1:0] z_lo,
  input  logic signed [DW-1:0] z_hi,
  output logic                 tile_valid,
  output logic        [IW-1:0] tile_idx,
  output logic signed [DW-1:0] tile_depth,
  output logic                 done
);
  logic signed [AW-1:0] init, step_x, step_y;
  logic signed [AW-1:0] acc, row_base, sx_q, sy_q;
  logic signed [DW-1:0] lo_q, hi_q;
  logic                 accept, fire, row_end, last;
  logic        [IW-1:0] idx;

  tde_setup #(.CW(CW), .DW(DW), .XW(XW), .AW(AW), .TW(TW), .TH(TH)) u_setup (
    .mode(bound_e'(mode_max)), .a(coef_a), .b(coef_b), .c(coef_c),
    .x0(orig_x), .y0(orig_y), .init(init), .step_x(step_x), .step_y(step_y)
  );

  tde_walker #(.COLS(ST_COLS), .ROWS(ST_ROWS)) u_walk (
    .clk(clk), .rst(rst), .go(start), .accept(accept), .fire(fire),
    .row_end(row_end), .last(last), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      row_base <= '0;
      sx_q     <= '0;
      sy_q     <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else if (accept) begin
      acc      <= init;
      row_base <= init;
      sx_q     <= step_x;
      sy_q     <= step_y;
      lo_q     <= z_lo;
      hi_q     <= z_hi;
    end else if (fire) begin
      if (row_end) begin
        row_base <= row_base + sy_q;
        acc      <= row_base + sy_q;
      end else begin
        acc <= acc + sx_q;
      end
    end
  end

  tde_clamp #(.DW(DW), .AW(AW), .IW(IW)) u_clamp (
    .clk(clk), .rst(rst), .fire(fire), .last(last), .idx(idx), .val(acc),
    .lo(lo_q), .hi(hi_q), .o_valid(tile_valid), .o_idx(tile_idx),
    .o_depth(tile_depth), .o_done(done)
  );
endmodule

// File: rtl/tde_checker.sv
module tde_checker #(
  parameter int DW = 24,
  parameter int IW = 3,
  parameter int NT = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tile_valid,
  input logic        [IW-1:0] tile_idx,
  input logic signed [DW-1:0] tile_depth,
  input logic                 done,
  input logic signed [DW-1:0] lo_q,
  input logic signed [DW-1:0] hi_q
);
  localparam logic [IW-1:0] LAST = IW'(NT - 1);

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !tile_valid && !done);

  a_r2_first_tile: assert property (@(posedge clk) disable iff (rst)
    $rose(tile_valid) |-> tile_idx == '0);

  a_r2_next_tile: assert property (@(posedge clk) disable iff (rst)
    tile_valid && tile_idx != LAST |=> tile_valid && tile_idx == $past(tile_idx) + 1'b1);

  a_r5_in_range: assert property (@(posedge clk) disable iff (rst)
    tile_valid |-> tile_depth >= lo_q && tile_depth <= hi_q);

  a_r6_done_on_last: assert property (@(posedge clk) disable iff (rst)
    done |-> tile_valid && tile_idx == LAST);

  a_r6_last_has_done: assert property (@(posedge clk) disable iff (rst)
    tile_valid && tile_idx == LAST |-> done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind tile_depth_eval tde_checker #(.DW(DW), .IW(IW), .NT(NT)) u_chk (
  .clk(clk), .rst(rst), .tile_valid(tile_valid), .tile_idx(tile_idx),
  .tile_depth(tile_depth), .done(done), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/sim_tile_depth_eval.sv
module sim_tile_depth_eval;
  typedef struct packed {
    logic signed [15:0] a;
    logic signed [15:0] b;
    logic signed [23:0] c;
    logic        [11:0] x;
    logic        [11:0] y;
    logic               mx;
    logic signed [23:0] lo;
    logic signed [23:0] hi;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{ 16'sd3,   16'sd5,   24'sd100,  12'd32,  12'd16,  1'b1, -24'sd1000000, 24'sd1000000},
    '{-16'sd3,   16'sd2,   24'sd200,  12'd64,  12'd8,   1'b1, -24'sd1000000, 24'sd1000000},
    '{ 16'sd4,  -16'sd6,   24'sd50,   12'd96,  12'd40,  1'b0, -24'sd1000000, 24'sd1000000},
    '{-16'sd2,  -16'sd1,   24'sd5000, 12'd160, 12'd24,  1'b0, -24'sd1000000, 24'sd1000000},
    '{ 16'sd0,   16'sd0,   24'sd777,  12'd200, 12'd200, 1'b1, -24'sd1000,    24'sd1000},
    '{ 16'sd50,  16'sd40,  24'sd0,    12'd64,  12'd0,   1'b1,  24'sd0,       24'sd3000},
    '{-16'sd10, -16'sd10,  24'sd0,    12'd100, 12'd100, 1'b0, -24'sd1500,    24'sd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode_max = 1'b0;
  logic signed [15:0] coef_a = '0, coef_b = '0;
  logic signed [23:0] coef_c = '0, z_lo = '0, z_hi = '0;
  logic [11:0] orig_x = '0, orig_y = '0;
  logic tile_valid, done;
  logic [2:0] tile_idx;
  logic signed [23:0] tile_depth;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tile_depth_eval u0 (
    .clk(clk), .rst(rst), .start(start), .mode_max(mode_max),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .orig_x(orig_x), .orig_y(orig_y), .z_lo(z_lo), .z_hi(z_hi),
    .tile_valid(tile_valid), .tile_idx(tile_idx), .tile_depth(tile_depth), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint expect_depth(input vec_t v, input int k);
    longint col = k % 4;
    longint row = k / 4;
    bit far_x = v.mx ? (v.a > 0) : (v.a < 0);
    bit far_y = v.mx ? (v.b > 0) : (v.b < 0);
    longint xs = longint'(v.x) + col * 8 + (far_x ? 8 : 0);
    longint ys = longint'(v.y) + row * 4 + (far_y ? 4 : 0);
    longint d  = longint'(v.a) * xs + longint'(v.b) * ys + longint'(v.c);
    if (d < longint'(v.lo)) d = longint'(v.lo);
    if (d > longint'(v.hi)) d = longint'(v.hi);
    return d;
  endfunction

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:    return "R3";
      2, 3:    return "R4";
      4:       return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic drive(input vec_t v);
    coef_a = v.a; coef_b = v.b; coef_c = v.c;
    orig_x = v.x; orig_y = v.y; mode_max = v.mx;
    z_lo = v.lo; z_hi = v.hi;
  endtask

  // Runs one supertile; with interrupt set, a second start with other inputs is
  // raised while tiles are still streaming (R7).
  task automatic run_vec(input vec_t v, input string tag, input bit interrupt, input vec_t other);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      #1;
      chk(tile_valid === 1'b1, "R2", "tile_valid", longint'(tile_valid), 1);
      chk(tile_idx === 3'(k), "R2", "tile_idx", longint'(tile_idx), k);
      chk(longint'(tile_depth) == expect_depth(v, k), interrupt ? "R7" : tag,
          "tile_depth", longint'(tile_depth), expect_depth(v, k));
      chk(done === (k == 7), "R6", "done", longint'(done), (k == 7));
      if (interrupt && k == 2) begin
        drive(other);
        start = 1'b1;
      end
      if (interrupt && k == 3) start = 1'b0;
    end
    @(posedge clk);
    #1;
    chk(tile_valid === 1'b0, interrupt ? "R7" : "R6", "valid after last", longint'(tile_valid), 0);
    chk(done === 1'b0, "R6", "done after last", longint'(done), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet after reset
    chk(tile_valid === 1'b0, "R1", "valid in reset", longint'(tile_valid), 0);
    chk(done === 1'b0, "R1", "done in reset", longint'(done), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(tile_valid === 1'b0, "R1", "valid idle", longint'(tile_valid), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], vec_tag(i), 1'b0, VEC[i]);

    // R7: second start while busy is ignored
    run_vec(VEC[0], "R7", 1'b1, VEC[2]);
    repeat (2) @(posedge clk);
    #1;
    chk(tile_valid === 1'b0, "R7", "no second run", longint'(tile_valid), 0);

    // R5: depth exactly equal to a range limit passes unchanged
    run_vec('{16'sd0, 16'sd0, 24'sd42, 12'd0, 12'd0, 1'b0, 24'sd42, 24'sd42}, "R5", 1'b0, VEC[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule